// File: doc/BRIEF.md
# Round-Robin Replicated Datapath Unit

This block keeps a throughput of one result per clock while giving each copy of its arithmetic logic a full N clock periods to settle. It holds N identical lanes, each a load-enabled input register followed by the same combinational function. A modulo-N phase counter steps once per clock. Its one-hot decode picks the single lane that captures the incoming word in that cycle, so each lane is loaded once every N cycles and the lanes' load points are staggered by one clock each. Consecutive input words therefore land in consecutive lanes and wrap back to lane 0 after lane N-1.

The same counter value drives an output multiplexer. On the edge where a lane is about to be reloaded, the multiplexer registers that lane's finished result. Every accepted word comes out exactly N cycles after the edge that captured it, and words leave in the order they came in. The capture and the launch both use a clock enable on the base clock. No derived clock is generated.

The function is y = (x * MUL + ADD) mod 2^W.

Top module: `rr_replica_unit`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0.
- R2: A word x sampled with in_valid_i high at a rising edge is presented on out_data_o as (x*MUL + ADD) mod 2^W, with defaults W=16, MUL=3, ADD=5. This holds for all operand values, including values whose product wraps past 2^W.
- R3: A gap-free stream of valid words yields one valid result per cycle, in the input order, with no gaps.
- R4: out_valid_o after the N-th rising edge following a given edge equals in_valid_i sampled at that given edge. A cycle with in_valid_i low produces a cycle with out_valid_o low, N cycles later. The default is N=4.
- R5: After reset is released, out_valid_o stays 0 for the first N rising edges, even when valid words are offered from the first edge on.
- R6: Asserting reset in the middle of a stream discards every word in flight. No result from before the reset appears after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word is valid this cycle |
| in_data_i | input | W | Input operand |
| out_valid_o | output | 1 | Result valid this cycle |
| out_data_o | output | W | Function result |

## Verification
The reference model is a queue of the driven inputs, delayed by N cycles, and it is compared with the outputs on every cycle.

- **Start-up:** valid words are offered right after reset, which separates a correct N-cycle fill from an early or late first result.
- **Dense stream:** a long stream of incrementing words shows a lane swap or a skipped phase as an ordering error.
- **Random gaps:** a random valid pattern checks that the valid flags line up at every counter phase.
- **Wrapping operands:** operands such as 0, all-ones and values near the wrap point test the modular arithmetic.
- **Mid-stream reset:** asserting reset while words are in flight shows whether stale lane contents survive the reset.

// File: rtl/rr_pkg.sv
package rr_pkg;
  // Wide evaluation; callers truncate to their data width.
  function automatic logic [63:0] rr_apply(input logic [63:0] x,
                                           input int unsigned mul,
                                           input int unsigned add);
    return x * 64'(mul) + 64'(add);
  endfunction
endpackage

// File: rtl/rr_phase_ctr.sv
module rr_phase_ctr #(
  parameter int unsigned N  = 4,
  localparam int unsigned CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] sel_o,
  output logic [N-1:0]  ld_o
);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            sel_o <= '0;
    else if (sel_o == LAST) sel_o <= '0;
    else                    sel_o <= sel_o + 1'b1;
  end

  for (genvar k = 0; k < N; k++) begin : g_dec
    assign ld_o[k] = (sel_o == CW'(k));
  end
endmodule

// File: rtl/rr_lane.sv
module rr_lane #(
  parameter int unsigned W   = 16,
  parameter int unsigned MUL = 3,
  parameter int unsigned ADD = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] res_o
);
  logic [W-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q_reset: begin
        vld_o <= 1'b0;
        dat_q <= '0;
      end
    end else if (ld_i) begin
      vld_o <= vld_i;
      if (vld_i) dat_q <= dat_i;  // skip data toggling on bubbles
    end
  end

  // Settles over N base periods before the output mux samples it.
  assign res_o = W'(rr_pkg::rr_apply(64'(dat_q), MUL, ADD));
endmodule

// File: rtl/rr_out_mux.sv
module rr_out_mux #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 16,
  localparam int unsigned CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CW-1:0]       sel_i,
  input  logic [N-1:0]        vld_i,
  input  logic [N-1:0][W-1:0] res_i,
  output logic                vld_o,
  output logic [W-1:0]        dat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      dat_o <= '0;
    end else begin
      vld_o <= vld_i[sel_i];
      dat_o <= res_i[sel_i];
    end
  end
endmodule

// File: rtl/rr_replica_unit.sv
module rr_replica_unit #(
  parameter int unsigned N   = 4,
  parameter int unsigned W   = 16,
  parameter int unsigned MUL = 3,
  parameter int unsigned ADD = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o
);
  localparam int unsigned CW = (N > 1) ? $clog2(N) : 1;

  logic [CW-1:0]       sel;
  logic [N-1:0]        lane_ld;
  logic [N-1:0]        lane_vld;
  logic [N-1:0][W-1:0] lane_res;

  rr_phase_ctr #(.N(N)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_o (sel),
    .ld_o  (lane_ld)
  );

  for (genvar k = 0; k < N; k++) begin : g_lane
    rr_lane #(.W(W), .MUL(MUL), .ADD(ADD)) u_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ld_i  (lane_ld[k]),
      .vld_i (in_valid_i),
      .dat_i (in_data_i),
      .vld_o (lane_vld[k]),
      .res_o (lane_res[k])
    );
  end

  // Lane sel is sampled on the same edge that reloads it.
  rr_out_mux #(.N(N), .W(W)) u_mux (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (sel),
    .vld_i (lane_vld),
    .res_i (lane_res),
    .vld_o (out_valid_o),
    .dat_o (out_data_o)
  );
endmodule

// File: rtl/rr_replica_unit_chk.sv
module rr_replica_unit_chk #(
  parameter int unsigned N   = 4,
  parameter int unsigned W   = 16,
  parameter int unsigned MUL = 3,
  parameter int unsigned ADD = 5,
  localparam int unsigned CW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic [W-1:0]  in_data_i,
  input logic          out_valid_o,
  input logic [W-1:0]  out_data_o,
  input logic [CW-1:0] sel_i,
  input logic [N-1:0]  lane_ld_i
);
  logic [N:0]        vh;
  logic [N:0][W-1:0] dh;
  int unsigned       since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vh <= '0;
      dh <= '0;
      since_rst <= 0;
    end else begin
      vh <= {vh[N-1:0], in_valid_i};
      dh <= {dh[N-1:0], in_data_i};
      if (since_rst <= N) since_rst <= since_rst + 1;
    end
  end

  assert_quiet_in_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !out_valid_o);

  assert_fill_delay_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst <= N) |-> !out_valid_o);

  assert_valid_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == vh[N]);

  assert_result_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_data_o == W'(dh[N] * MUL + ADD));

  assert_single_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(lane_ld_i));

  assert_phase_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> sel_i == (($past(sel_i) == CW'(N - 1)) ? '0 : $past(sel_i) + 1'b1));
endmodule

bind rr_replica_unit rr_replica_unit_chk #(.N(N), .W(W), .MUL(MUL), .ADD(ADD)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_data_i  (in_data_i),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o),
  .sel_i      (sel),
  .lane_ld_i  (lane_ld)
);

// File: tb/tb_rr_replica_unit.sv
module tb_rr_replica_unit;
  localparam int N   = 4;
  localparam int W   = 16;
  localparam int MUL = 3;
  localparam int ADD = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         out_valid;
  logic [W-1:0] out_data;

  int n_run = 0;
  int n_fail = 0;
  logic [W:0] hist[$];

  always #10 clk = ~clk;  // 50 MHz

  rr_replica_unit #(.N(N), .W(W), .MUL(MUL), .ADD(ADD)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .in_data_i  (in_data),
    .out_valid_o(out_valid),
    .out_data_o (out_data)
  );

  function automatic logic [W-1:0] ref_f(input logic [W-1:0] x);
    longint t;
    t = longint'(x) * MUL + ADD;
    return t[W-1:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic seed_hist();
    hist.delete();
    for (int i = 0; i < N; i++) hist.push_back('0);
  endtask

  task automatic step(input logic v, input logic [W-1:0] d, input string tag);
    logic [W:0] e;
    in_valid = v;
    in_data  = d;
    @(posedge clk);
    hist.push_back({v, d});
    @(negedge clk);
    e = hist.pop_front();
    chk({tag, " valid"}, 32'(out_valid), 32'(e[W]));
    if (e[W]) chk({tag, " data"}, 32'(out_data), 32'(ref_f(e[W-1:0])));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: outputs quiet in reset
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    seed_hist();

    // R5: valid words from the first edge; first N results must be invalid
    for (int i = 0; i < 2 * N; i++) step(1'b1, W'(16'h100 + i), "R5");

    // R3: dense ordered stream
    for (int i = 0; i < 40; i++) step(1'b1, W'(i * 7 + 1), "R3");

    // R4: random valid gaps at every phase
    for (int i = 0; i < 200; i++) step(1'($urandom_range(0, 1)), W'($urandom), "R4");
    for (int i = 0; i < N + 1; i++) step(1'b0, '1, "R4 idle");

    // R2: wrap-around operands
    step(1'b1, 16'h0000, "R2");
    step(1'b1, 16'hFFFF, "R2");
    step(1'b1, 16'h5555, "R2");
    step(1'b1, 16'h5556, "R2");
    step(1'b1, 16'hAAAA, "R2");
    step(1'b1, 16'h8000, "R2");
    for (int i = 0; i < N + 1; i++) step(1'b0, '0, "R2 drain");

    // R6: reset mid-stream discards in-flight words
    for (int i = 0; i < N - 1; i++) step(1'b1, W'(16'h3000 + i), "R6 pre");
    rst_n = 1'b0;
    #1;
    chk("R1 async reset valid", 32'(out_valid), 32'd0);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    seed_hist();
    for (int i = 0; i < N + 2; i++) step(1'b0, '0, "R6");
    for (int i = 0; i < 3 * N; i++) step(1'b1, W'(16'hBEEF + i), "R6 restart");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule